// File: doc/BRIEF.md
# Multi-Chip Flash State Arbiter

This block keeps the operating condition of every chip in a bank of flash devices and decides when client requests and bank-wide housekeeping may touch a chip. Each chip sits in one of eight conditions. Four are idle: ready, status readout, CFI query and JEDEC query. Two are busy: programming and erasing. Two are parked: synchronising and power-down suspended. A client asks for a read, a program, an erase or a change of idle mode on one chip. The request is held off until that chip can take it. A completion strobe returns a busy chip to ready.

Three bank-wide commands visit the chips one per clock cycle. Suspend walks upwards and parks every chip in the suspended condition. If it meets a chip that is not idle, it gives up, unparks the chips it already parked in downward order and reports a busy error. Sync walks upwards and waits at each busy chip until that chip goes idle. Once every chip is parked, it unparks them in downward order. Resume walks upwards and unparks every suspended chip. When a chip is parked, its idle condition is saved, and unparking restores that condition. Whenever a chip moves from a non-idle condition to an idle one, a one-cycle wake strobe fires for that chip, so that stalled requesters know when to retry.

Top module: `flash_state_arbiter`

## Requirements
- R1: After reset, every chip is ready (code 0), no wake strobe is high, no result strobe is high, and `gcmd_ready` is 1.
- R2: Condition codes are: ready 0, status 1, CFI query 2, JEDEC query 3, programming 4, erasing 5, synchronising 6, suspended 7. Request kinds are: read 0, program 1, erase 2, mode 3. Read, program and erase are accepted (`op_ready`=1) only when the target chip is ready. Mode is accepted when the chip is in any idle condition (code 0 to 3). On the clock edge that accepts a request: program sets code 4, erase sets code 5, mode sets code `op_mode`, and read leaves the code unchanged.
- R3: `fin_valid` on a chip in code 4 or 5 sets it to ready on the next edge. On a chip in any other condition, `fin_valid` has no effect.
- R4: `chip_wake[i]` is high for exactly the one cycle after chip i moves from a code of 4 or above to a code of 0 to 3.
- R5: Suspend with every chip idle puts every chip in code 7 and pulses `susp_ok`. It visits one chip per cycle.
- R6: Suspend that meets a non-idle chip k pulses `susp_err`. Chips k-1 down to 0 are restored to their saved idle codes, one per cycle in descending order, and every chip ends with the code it had before the command.
- R7: Sync parks chips in ascending order in code 6. It waits at a non-idle chip until that chip becomes idle. It then restores all chips in descending order and pulses `sync_done`, leaving each chip in its prior idle code.
- R8: Resume returns each chip in code 7 to its saved idle code, visiting chips in ascending order, and pulses `resume_done`. If any chip is not in code 7, `resume_warn` pulses with `resume_done`, and that chip is left unchanged.
- R9: Global commands (1 sync, 2 suspend, 3 resume) are taken only while `gcmd_ready` is 1. A command offered while a walk is in progress is ignored. While a walk is in progress, a request to the chip the walk currently points at is held off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Client request present |
| op_kind | input | 2 | Request kind (R2 codes) |
| op_chip | input | IW | Target chip index |
| op_mode | input | 2 | Idle code for a mode request |
| op_ready | output | 1 | Request is taken this cycle |
| fin_valid | input | 1 | Program or erase finished |
| fin_chip | input | IW | Chip that finished |
| gcmd_valid | input | 1 | Global command present |
| gcmd | input | 2 | Global command code |
| gcmd_ready | output | 1 | No walk in progress |
| chip_state | output | 3*N_CHIPS | Condition code per chip, chip i at bits 3i+2:3i |
| chip_wake | output | N_CHIPS | Per-chip return-to-idle strobe |
| sync_done | output | 1 | Sync finished |
| susp_ok | output | 1 | Suspend succeeded |
| susp_err | output | 1 | Suspend failed, chips restored |
| resume_done | output | 1 | Resume finished |
| resume_warn | output | 1 | Resume found a chip that was not suspended |

## Verification
The directed patterns cover several situations. A suspend is issued with a busy chip in the middle of the bank, and the recorded order of wake strobes is compared with a strictly descending rollback, so a wrong rollback direction or a missing restore is caught. A suspend with all chips idle is followed by two resumes; the second resume separates the warning path from the restore path. A sync is started with a busy chip, and a suspend is offered while the sync is still walking, which shows whether the walk really waits and whether commands are refused during it. A random mix of requests, completions and global commands then compares every chip code against a bench model; completions aimed at idle chips and requests aimed at non-ready chips check that ignored stimulus leaves the state alone.

// File: rtl/fa_pkg.sv
package fa_pkg;

  typedef enum logic [2:0] {
    ST_READY = 3'd0,
    ST_STAT  = 3'd1,
    ST_CFIQ  = 3'd2,
    ST_JEDQ  = 3'd3,
    ST_PROG  = 3'd4,
    ST_ERAS  = 3'd5,
    ST_SYNC  = 3'd6,
    ST_SUSP  = 3'd7
  } chip_st_e;

  localparam logic [1:0] OP_READ = 2'd0;
  localparam logic [1:0] OP_PROG = 2'd1;
  localparam logic [1:0] OP_ERAS = 2'd2;
  localparam logic [1:0] OP_MODE = 2'd3;

  localparam logic [1:0] GC_NONE = 2'd0;
  localparam logic [1:0] GC_SYNC = 2'd1;
  localparam logic [1:0] GC_SUSP = 2'd2;
  localparam logic [1:0] GC_RES  = 2'd3;

  // Idle conditions occupy the lower half of the code space.
  function automatic logic st_idle(input logic [2:0] s);
    return ~s[2];
  endfunction

endpackage

// File: rtl/fa_chip_slot.sv
module fa_chip_slot
  import fa_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       op_we,
  input  logic [2:0] op_st,
  input  logic       park,
  input  logic [2:0] park_st,
  input  logic       restore,
  input  logic       fin,
  output logic [2:0] st_o,
  output logic       wake_o
);

  logic [2:0] st_q;
  logic [2:0] st_d;
  logic [1:0] saved_q;

  always_comb begin
    st_d = st_q;
    if (restore) begin
      st_d = {1'b0, saved_q};
    end else if (park) begin
      st_d = park_st;
    end else if (op_we) begin
      st_d = op_st;
    end else if (fin && (st_q == ST_PROG || st_q == ST_ERAS)) begin
      st_d = ST_READY;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_READY;
      saved_q <= 2'd0;
      wake_o  <= 1'b0;
    end else begin
      st_q   <= st_d;
      wake_o <= !st_idle(st_q) && st_idle(st_d);
      if (park) begin
        saved_q <= st_q[1:0];
      end
    end
  end

  assign st_o = st_q;

endmodule

// File: rtl/fa_op_gate.sv
module fa_op_gate
  import fa_pkg::*;
#(
  parameter int N_CHIPS = 4,
  localparam int IW = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input  logic               op_valid,
  input  logic [1:0]         op_kind,
  input  logic [IW-1:0]      op_chip,
  input  logic [1:0]         op_mode,
  input  logic [3*N_CHIPS-1:0] chip_st_i,
  input  logic               walk_busy,
  input  logic [IW-1:0]      walk_idx,
  output logic               op_ready_o,
  output logic [N_CHIPS-1:0] op_we_o,
  output logic [2:0]         op_st_o
);

  logic [2:0] cur;
  logic       in_range;
  logic       ok_state;

  always_comb begin
    cur      = ST_READY;
    in_range = 1'b0;
    for (int i = 0; i < N_CHIPS; i++) begin
      if (op_chip == IW'(i)) begin
        cur      = chip_st_i[3*i +: 3];
        in_range = 1'b1;
      end
    end
  end

  always_comb begin
    if (op_kind == OP_MODE) ok_state = st_idle(cur);
    else                    ok_state = (cur == ST_READY);
  end

  assign op_ready_o = in_range && ok_state && !(walk_busy && op_chip == walk_idx);

  always_comb begin
    case (op_kind)
      OP_PROG: op_st_o = ST_PROG;
      OP_ERAS: op_st_o = ST_ERAS;
      OP_MODE: op_st_o = {1'b0, op_mode};
      default: op_st_o = cur;
    endcase
  end

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_we
    assign op_we_o[g] = op_valid && op_ready_o && (op_chip == IW'(g)) && (op_kind != OP_READ);
  end

endmodule

// File: rtl/fa_walk_ctrl.sv
module fa_walk_ctrl
  import fa_pkg::*;
#(
  parameter int N_CHIPS = 4,
  localparam int IW = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 gcmd_valid,
  input  logic [1:0]           gcmd,
  input  logic [3*N_CHIPS-1:0] chip_st_i,
  output logic                 busy_o,
  output logic [IW-1:0]        idx_o,
  output logic [N_CHIPS-1:0]   park_o,
  output logic [2:0]           park_st_o,
  output logic [N_CHIPS-1:0]   restore_o,
  output logic                 sync_done_o,
  output logic                 susp_ok_o,
  output logic                 susp_err_o,
  output logic                 res_done_o,
  output logic                 res_warn_o
);

  typedef enum logic [2:0] {
    W_IDLE, W_SUSP, W_ROLL, W_SYNC, W_UNSYNC, W_RES
  } walk_e;

  localparam logic [IW-1:0] LAST = IW'(N_CHIPS - 1);

  walk_e       ws_q;
  logic [IW-1:0] idx_q;
  logic        warn_q;
  logic [2:0]  cur;
  logic        cur_idle;
  logic        hit_park;
  logic        hit_rest;

  assign cur      = chip_st_i[3*idx_q +: 3];
  assign cur_idle = st_idle(cur);

  always_comb begin
    hit_park  = 1'b0;
    hit_rest  = 1'b0;
    park_st_o = ST_SUSP;
    case (ws_q)
      W_SUSP:   hit_park = cur_idle;
      W_SYNC: begin
        hit_park  = cur_idle;
        park_st_o = ST_SYNC;
      end
      W_ROLL, W_UNSYNC: hit_rest = 1'b1;
      W_RES:    hit_rest = (cur == ST_SUSP);
      default: ;
    endcase
  end

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_sel
    assign park_o[g]    = hit_park && (idx_q == IW'(g));
    assign restore_o[g] = hit_rest && (idx_q == IW'(g));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ws_q        <= W_IDLE;
      idx_q       <= '0;
      warn_q      <= 1'b0;
      sync_done_o <= 1'b0;
      susp_ok_o   <= 1'b0;
      susp_err_o  <= 1'b0;
      res_done_o  <= 1'b0;
      res_warn_o  <= 1'b0;
    end else begin
      sync_done_o <= 1'b0;
      susp_ok_o   <= 1'b0;
      susp_err_o  <= 1'b0;
      res_done_o  <= 1'b0;
      res_warn_o  <= 1'b0;
      case (ws_q)
        W_IDLE: begin
          idx_q  <= '0;
          warn_q <= 1'b0;
          if (gcmd_valid) begin
            case (gcmd)
              GC_SYNC: ws_q <= W_SYNC;
              GC_SUSP: ws_q <= W_SUSP;
              GC_RES:  ws_q <= W_RES;
              default: ws_q <= W_IDLE;
            endcase
          end
        end
        W_SUSP: begin
          if (cur_idle) begin
            if (idx_q == LAST) begin
              ws_q      <= W_IDLE;
              susp_ok_o <= 1'b1;
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end else if (idx_q == '0) begin
            ws_q       <= W_IDLE;
            susp_err_o <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
            ws_q  <= W_ROLL;
          end
        end
        W_ROLL: begin
          if (idx_q == '0) begin
            ws_q       <= W_IDLE;
            susp_err_o <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        W_SYNC: begin
          if (cur_idle) begin
            if (idx_q == LAST) ws_q <= W_UNSYNC;
            else               idx_q <= idx_q + 1'b1;
          end
        end
        W_UNSYNC: begin
          if (idx_q == '0) begin
            ws_q        <= W_IDLE;
            sync_done_o <= 1'b1;
          end else begin
            idx_q <= idx_q - 1'b1;
          end
        end
        W_RES: begin
          if (cur != ST_SUSP) warn_q <= 1'b1;
          if (idx_q == LAST) begin
            ws_q       <= W_IDLE;
            res_done_o <= 1'b1;
            res_warn_o <= warn_q || (cur != ST_SUSP);
          end else begin
            idx_q <= idx_q + 1'b1;
          end
        end
        default: ws_q <= W_IDLE;
      endcase
    end
  end

  assign busy_o = (ws_q != W_IDLE);
  assign idx_o  = idx_q;

endmodule

// File: rtl/flash_state_arbiter.sv
module flash_state_arbiter
  import fa_pkg::*;
#(
  parameter int N_CHIPS = 4,
  localparam int IW = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 op_valid,
  input  logic [1:0]           op_kind,
  input  logic [IW-1:0]        op_chip,
  input  logic [1:0]           op_mode,
  output logic                 op_ready,
  input  logic                 fin_valid,
  input  logic [IW-1:0]        fin_chip,
  input  logic                 gcmd_valid,
  input  logic [1:0]           gcmd,
  output logic                 gcmd_ready,
  output logic [3*N_CHIPS-1:0] chip_state,
  output logic [N_CHIPS-1:0]   chip_wake,
  output logic                 sync_done,
  output logic                 susp_ok,
  output logic                 susp_err,
  output logic                 resume_done,
  output logic                 resume_warn
);

  logic                 walk_busy;
  logic [IW-1:0]        walk_idx;
  logic [N_CHIPS-1:0]   park;
  logic [N_CHIPS-1:0]   restore;
  logic [2:0]           park_st;
  logic [N_CHIPS-1:0]   op_we;
  logic [2:0]           op_st;

  fa_op_gate #(.N_CHIPS(N_CHIPS)) u_gate (
    .op_valid   (op_valid),
    .op_kind    (op_kind),
    .op_chip    (op_chip),
    .op_mode    (op_mode),
    .chip_st_i  (chip_state),
    .walk_busy  (walk_busy),
    .walk_idx   (walk_idx),
    .op_ready_o (op_ready),
    .op_we_o    (op_we),
    .op_st_o    (op_st)
  );

  fa_walk_ctrl #(.N_CHIPS(N_CHIPS)) u_walk (
    .clk         (clk),
    .rst         (rst),
    .gcmd_valid  (gcmd_valid),
    .gcmd        (gcmd),
    .chip_st_i   (chip_state),
    .busy_o      (walk_busy),
    .idx_o       (walk_idx),
    .park_o      (park),
    .park_st_o   (park_st),
    .restore_o   (restore),
    .sync_done_o (sync_done),
    .susp_ok_o   (susp_ok),
    .susp_err_o  (susp_err),
    .res_done_o  (resume_done),
    .res_warn_o  (resume_warn)
  );

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_slot
    fa_chip_slot u_slot (
      .clk     (clk),
      .rst     (rst),
      .op_we   (op_we[g]),
      .op_st   (op_st),
      .park    (park[g]),
      .park_st (park_st),
      .restore (restore[g]),
      .fin     (fin_valid && (fin_chip == IW'(g))),
      .st_o    (chip_state[3*g +: 3]),
      .wake_o  (chip_wake[g])
    );
  end

  assign gcmd_ready = !walk_busy;

endmodule

// File: rtl/flash_state_arbiter_chk.sv
module flash_state_arbiter_chk
  import fa_pkg::*;
#(
  parameter int N_CHIPS = 4,
  localparam int IW = (N_CHIPS > 1) ? $clog2(N_CHIPS) : 1
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 op_valid,
  input logic [1:0]           op_kind,
  input logic [IW-1:0]        op_chip,
  input logic                 op_ready,
  input logic                 fin_valid,
  input logic [IW-1:0]        fin_chip,
  input logic [3*N_CHIPS-1:0] chip_state,
  input logic [N_CHIPS-1:0]   chip_wake,
  input logic                 sync_done,
  input logic                 susp_ok,
  input logic                 susp_err,
  input logic                 resume_done,
  input logic                 resume_warn
);

  logic [2:0] st_a [N_CHIPS];
  logic       all_susp;
  logic       any_sync;

  for (genvar g = 0; g < N_CHIPS; g++) begin : g_arr
    assign st_a[g] = chip_state[3*g +: 3];
  end

  always_comb begin
    all_susp = 1'b1;
    any_sync = 1'b0;
    for (int i = 0; i < N_CHIPS; i++) begin
      if (st_a[i] != ST_SUSP) all_susp = 1'b0;
      if (st_a[i] == ST_SYNC) any_sync = 1'b1;
    end
  end

  // R2: an accepted program request leaves the chip programming
  a_r2_prog_taken: assert property (@(posedge clk) disable iff (rst)
    (op_valid && op_ready && op_kind == OP_PROG && int'(op_chip) < N_CHIPS)
      |=> st_a[$past(op_chip)] == ST_PROG);

  // R3: completion on a busy chip returns it to ready
  a_r3_fin_ready: assert property (@(posedge clk) disable iff (rst)
    (fin_valid && int'(fin_chip) < N_CHIPS &&
     (st_a[fin_chip] == ST_PROG || st_a[fin_chip] == ST_ERAS))
      |=> st_a[$past(fin_chip)] == ST_READY);

  // R4: a wake strobe marks a fresh return to an idle code
  for (genvar g = 0; g < N_CHIPS; g++) begin : g_wake
    a_r4_wake_edge: assert property (@(posedge clk) disable iff (rst)
      chip_wake[g] |-> (!st_a[g][2] && $past(st_a[g][2])));
  end

  // R5: success leaves the whole bank suspended
  a_r5_all_parked: assert property (@(posedge clk) disable iff (rst)
    susp_ok |-> all_susp);

  // R7: sync completion leaves no chip parked
  a_r7_unparked: assert property (@(posedge clk) disable iff (rst)
    sync_done |-> !any_sync);

  // R8: warning only accompanies resume completion
  a_r8_warn_with_done: assert property (@(posedge clk) disable iff (rst)
    resume_warn |-> resume_done);

  // R9: one walk at a time, so at most one result strobe
  a_r9_one_result: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sync_done, susp_ok, susp_err, resume_done}));

endmodule

bind flash_state_arbiter flash_state_arbiter_chk #(.N_CHIPS(N_CHIPS)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op_valid    (op_valid),
  .op_kind     (op_kind),
  .op_chip     (op_chip),
  .op_ready    (op_ready),
  .fin_valid   (fin_valid),
  .fin_chip    (fin_chip),
  .chip_state  (chip_state),
  .chip_wake   (chip_wake),
  .sync_done   (sync_done),
  .susp_ok     (susp_ok),
  .susp_err    (susp_err),
  .resume_done (resume_done),
  .resume_warn (resume_warn)
);

// File: tb/flash_state_arbiter_bench.sv
`timescale 1ns/1ps
module flash_state_arbiter_bench;

  localparam int N = 4;
  localparam int IW = 2;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          op_valid = 1'b0;
  logic [1:0]    op_kind = 2'd0;
  logic [IW-1:0] op_chip = '0;
  logic [1:0]    op_mode = 2'd0;
  logic          op_ready;
  logic          fin_valid = 1'b0;
  logic [IW-1:0] fin_chip = '0;
  logic          gcmd_valid = 1'b0;
  logic [1:0]    gcmd = 2'd0;
  logic          gcmd_ready;
  logic [3*N-1:0] chip_state;
  logic [N-1:0]  chip_wake;
  logic          sync_done, susp_ok, susp_err, resume_done, resume_warn;

  int n_chk = 0;
  int n_fail = 0;
  bit ended = 0;
  int exp_st [N];
  int exp_old [N];

  always #2.5 clk = ~clk;

  flash_state_arbiter #(.N_CHIPS(N)) u_flash_state_arbiter (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_kind(op_kind), .op_chip(op_chip),
    .op_mode(op_mode), .op_ready(op_ready), .fin_valid(fin_valid), .fin_chip(fin_chip),
    .gcmd_valid(gcmd_valid), .gcmd(gcmd), .gcmd_ready(gcmd_ready),
    .chip_state(chip_state), .chip_wake(chip_wake), .sync_done(sync_done),
    .susp_ok(susp_ok), .susp_err(susp_err), .resume_done(resume_done),
    .resume_warn(resume_warn)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic chk_states(input string req);
    for (int i = 0; i < N; i++) chk(req, int'(chip_state[3*i +: 3]), exp_st[i]);
  endtask

  function automatic int pulses();
    return int'({sync_done, susp_ok, susp_err, resume_done, resume_warn});
  endfunction

  function automatic bit exp_rdy(input int kind, input int chip);
    if (kind == 3) return exp_st[chip] < 4;
    return exp_st[chip] == 0;
  endfunction

  task automatic do_op(input int kind, input int chip, input int mode);
    bit rdy;
    int woke;
    @(negedge clk);
    op_valid = 1'b1; op_kind = 2'(kind); op_chip = IW'(chip); op_mode = 2'(mode);
    #1;
    rdy = exp_rdy(kind, chip);
    chk("R2 op_ready", int'(op_ready), int'(rdy));
    @(negedge clk);
    op_valid = 1'b0;
    if (rdy) begin
      if (kind == 1) exp_st[chip] = 4;
      else if (kind == 2) exp_st[chip] = 5;
      else if (kind == 3) exp_st[chip] = mode;
    end
    chk_states("R2 state after request");
    woke = int'(chip_wake);
    chk("R4 no wake on request", woke, 0);
  endtask

  task automatic do_fin(input int chip);
    int ew;
    @(negedge clk);
    fin_valid = 1'b1; fin_chip = IW'(chip);
    @(negedge clk);
    fin_valid = 1'b0;
    ew = 0;
    if (exp_st[chip] == 4 || exp_st[chip] == 5) begin
      exp_st[chip] = 0;
      ew = 1 << chip;
    end
    chk_states("R3 state after completion");
    chk("R4 wake after completion", int'(chip_wake), ew);
  endtask

  // Issue a global command with every chip settled; compare result strobes,
  // the order of wake strobes and the final codes against the model.
  task automatic run_g(input int cmd);
    int eseq, seq, epul, k;
    bit got;
    bit warn;
    eseq = 0; seq = 0; got = 0;
    if (cmd == 2) begin
      k = -1;
      for (int i = N - 1; i >= 0; i--) if (exp_st[i] >= 4) k = i;
      if (k < 0) begin
        for (int i = 0; i < N; i++) begin exp_old[i] = exp_st[i]; exp_st[i] = 7; end
        epul = 5'b01000;
      end else begin
        for (int j = k - 1; j >= 0; j--) eseq = eseq * 8 + j + 1;
        epul = 5'b00100;
      end
    end else if (cmd == 3) begin
      warn = 0;
      for (int i = 0; i < N; i++) begin
        if (exp_st[i] == 7) begin
          eseq = eseq * 8 + i + 1;
          exp_st[i] = exp_old[i];
        end else warn = 1;
      end
      epul = warn ? 5'b00011 : 5'b00010;
    end else begin
      for (int j = N - 1; j >= 0; j--) eseq = eseq * 8 + j + 1;
      epul = 5'b10000;
    end
    @(negedge clk);
    gcmd_valid = 1'b1; gcmd = 2'(cmd);
    @(negedge clk);
    gcmd_valid = 1'b0;
    chk("R9 busy after accept", int'(gcmd_ready), 0);
    for (int c = 0; c < 40 && !got; c++) begin
      @(negedge clk);
      for (int i = N - 1; i >= 0; i--) if (chip_wake[i]) seq = seq * 8 + i + 1;
      if (pulses() != 0) got = 1;
    end
    chk(cmd == 2 ? "R5/R6 result strobe" : (cmd == 3 ? "R8 result strobe" : "R7 result strobe"),
        pulses(), epul);
    chk(cmd == 2 ? "R6 restore order" : (cmd == 3 ? "R8 restore order" : "R7 restore order"),
        seq, eseq);
    chk_states(cmd == 2 ? "R5/R6 final codes" : (cmd == 3 ? "R8 final codes" : "R7 final codes"));
    @(negedge clk);
    chk("R9 ready after walk", int'(gcmd_ready), 1);
  endtask

  initial begin
    #(200000 * 5);
    if (!ended) begin
      ended = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int seq;
    bit seen;
    void'($urandom(32'd20240611));
    for (int i = 0; i < N; i++) begin exp_st[i] = 0; exp_old[i] = 0; end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk_states("R1 reset codes");
    chk("R1 no wake", int'(chip_wake), 0);
    chk("R1 no strobes", pulses(), 0);
    chk("R1 gcmd_ready", int'(gcmd_ready), 1);

    // R2 / R3 / R4 directed
    do_op(1, 1, 0);          // program chip 1
    do_op(0, 1, 0);          // read held off on busy chip
    do_op(3, 0, 2);          // chip 0 to CFI query
    do_op(2, 0, 0);          // erase held off on non-ready idle chip
    do_fin(0);               // completion ignored on idle chip
    do_fin(1);               // chip 1 back to ready with wake

    // R6 rollback from chip 2
    do_op(1, 2, 0);
    run_g(2);
    // R6 failure at chip 0
    do_op(3, 0, 0);
    do_op(2, 0, 0);
    run_g(2);
    do_fin(0);
    do_fin(2);

    // R5 then R8 twice
    do_op(3, 3, 3);
    do_op(3, 0, 1);
    run_g(2);
    do_op(0, 1, 0);          // read held off on suspended chip
    run_g(3);
    run_g(3);                // nothing suspended: warning

    // R7 / R9 directed: sync waits on busy chip 1
    do_op(3, 0, 0);
    do_op(3, 3, 0);
    do_op(1, 1, 0);
    @(negedge clk);
    gcmd_valid = 1'b1; gcmd = 2'd1;
    @(negedge clk);
    gcmd_valid = 1'b0;
    seen = 0; seq = 0;
    repeat (8) begin
      @(negedge clk);
      if (sync_done) seen = 1;
    end
    chk("R7 sync waits", int'(seen), 0);
    chk("R7 chip 0 parked", int'(chip_state[2:0]), 6);
    chk("R7 chip 1 still busy", int'(chip_state[5:3]), 4);
    chk("R7 chip 2 not yet visited", int'(chip_state[8:6]), 0);
    chk("R9 gcmd_ready low during walk", int'(gcmd_ready), 0);
    op_valid = 1'b1; op_kind = 2'd3; op_chip = 2'd1; op_mode = 2'd0;
    #1;
    chk("R9 request held off at walk index", int'(op_ready), 0);
    op_valid = 1'b0;
    gcmd_valid = 1'b1; gcmd = 2'd2;  // offered while busy: ignored
    @(negedge clk);
    gcmd_valid = 1'b0;
    fin_valid = 1'b1; fin_chip = 2'd1;
    @(negedge clk);
    fin_valid = 1'b0;
    exp_st[1] = 0;
    for (int c = 0; c < 40 && !seen; c++) begin
      for (int i = N - 1; i >= 0; i--) if (chip_wake[i]) seq = seq * 8 + i + 1;
      if (sync_done) seen = 1;
      else @(negedge clk);
    end
    chk("R7 sync finishes", int'(seen), 1);
    chk("R7 wake order", seq, ((((2 * 8 + 4) * 8 + 3) * 8 + 2) * 8 + 1));
    seen = 0;
    repeat (10) begin
      @(negedge clk);
      if (susp_ok || susp_err) seen = 1;
    end
    chk("R9 ignored suspend", int'(seen), 0);
    chk_states("R7 codes after sync");

    // random mix
    for (int it = 0; it < 300; it++) begin
      int r;
      bit busy_any;
      r = int'($urandom_range(0, 9));
      busy_any = 0;
      for (int i = 0; i < N; i++) if (exp_st[i] == 4 || exp_st[i] == 5) busy_any = 1;
      if (r <= 4) do_op(int'($urandom_range(0, 3)), int'($urandom_range(0, N - 1)),
                        int'($urandom_range(0, 3)));
      else if (r <= 6) do_fin(int'($urandom_range(0, N - 1)));
      else if (r == 7) run_g(2);
      else if (r == 8) run_g(3);
      else begin
        bit parked;
        parked = 0;
        for (int i = 0; i < N; i++) if (exp_st[i] >= 6) parked = 1;
        if (!busy_any && !parked) run_g(1);
        else run_g(3);
      end
    end

    if (!ended) begin
      ended = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule